// File: doc/BRIEF.md
# Prescaled 8-bit Timer with Compare Match

This block is an 8-bit up-counter advanced by ticks from a 10-bit free-running prescaler. A 3-bit clock-select field either holds the counter still or sets the tick rate to one of seven powers of two, from 1 to 1024 system clocks per tick. An 8-bit compare register is checked against the count on every tick. A match can reload the counter to zero, which gives a repeating period of compare value plus one ticks.

Two sticky event flags record a counter wrap and a compare match. Each flag has its own mask bit. An interrupt request is raised while a flag and its mask bit are both set. Software clears a flag by writing a one to its bit. Interrupt-service hardware can clear it instead with a one-cycle acknowledge pulse. A strobe input restarts the prescaler, so the next tick comes a whole division period after the strobe. Writing the count from software blocks the compare on the next tick. This keeps a freshly loaded value equal to the compare value from raising an event.

Top module: `ctr8_timer`

## Requirements
- R1: After synchronous reset, every register reads 0, both interrupt requests are low and the counter is stopped.
- R2: Control bits [2:0] select the tick rate: 0 stopped, 1 every clock, 2 every 8, 3 every 32, 4 every 64, 5 every 128, 6 every 256, 7 every 1024 clocks. The count changes only on a tick or a software write.
- R3: On a tick with the count at 0xFF, the count becomes 0x00 and flag bit 0 (overflow) is set. With control bit 3 at 0 the counter only counts up.
- R4: On a tick where the count equals the compare register, flag bit 1 (compare) is set.
- R5: With control bit 3 at 1, a compare match on a tick loads 0 instead of incrementing, which gives a period of compare value plus one ticks.
- R6: irq_ovf is flag bit 0 AND mask bit 0, and irq_cmp is flag bit 1 AND mask bit 1.
- R7: Writing 1 to a flag bit at address 4 clears it, and so does a one-cycle pulse on ack_ovf or ack_cmp. Writing 0 to a flag bit leaves it unchanged.
- R8: If a flag is set and cleared in the same cycle, the set takes priority and the flag stays 1.
- R9: A software write of the count loads it and suppresses the compare, including its reload, on the next tick.
- R10: A prescaler-clear pulse restarts division, so the first tick after it advances the count N clocks after the pulse's edge.
- R11: The address map is 0 count, 1 compare, 2 control ({mode, select} in bits [3:0]), 3 mask (bits [1:0]) and 4 flags (bits [1:0]). Unused bits and addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ack_ovf | input | 1 | Clears the overflow flag |
| ack_cmp | input | 1 | Clears the compare flag |
| psc_clr | input | 1 | Restarts the prescaler |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |

## Verification
The collision that matters is a flag being set by a tick in the same cycle that software or an acknowledge clears it. A directed case steers the count so that a compare match lands in the cycle where both the flag write and ack_cmp are driven, and then expects the flag to read 1. Random stimulus with a fixed seed then mixes writes, acknowledges and prescaler clears with short compare values, so that a set and a clear often meet in the same cycle. Each cycle's read data and interrupt outputs are compared against a cycle model kept in the bench.

// File: rtl/ctr8_pkg.sv
package ctr8_pkg;
    localparam int CNT_W  = 8;
    localparam int PRE_W  = 10;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 3;
    localparam int NFLAG  = 2;
    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_COUNT = 3'd0,
        A_CMP   = 3'd1,
        A_CTRL  = 3'd2,
        A_MASK  = 3'd3,
        A_FLAG  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic             ctc;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    // Low-bit mask of the prescaler: a tick fires when these bits are all ones.
    function automatic logic [PRE_W-1:0] div_mask(input logic [SEL_W-1:0] sel);
        int sh;
        case (sel)
            3'd1:    sh = 0;
            3'd2:    sh = 3;
            3'd3:    sh = 5;
            3'd4:    sh = 6;
            3'd5:    sh = 7;
            3'd6:    sh = 8;
            default: sh = PRE_W;
        endcase
        return PRE_W'((1 << sh) - 1);
    endfunction
endpackage

// File: rtl/ctr8_prescaler.sv
module ctr8_prescaler import ctr8_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             clr,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] msk;

    always_comb begin
        msk  = div_mask(sel);
        tick = (sel != '0) && !clr && ((pre_q & msk) == msk);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) pre_q <= '0;
        else            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/ctr8_counter.sv
module ctr8_counter import ctr8_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ctc,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf_set,
    output logic             cmp_set
);
    localparam logic [CNT_W-1:0] TOP = '1;
    logic guard_q;

    always_comb begin
        cmp_set = tick && !ld && !guard_q && (count == cmp_val);
        ovf_set = tick && !ld && (count == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            guard_q <= 1'b0;
        end else if (ld) begin
            count   <= ld_val;
            guard_q <= 1'b1;
        end else if (tick) begin
            count   <= (ctc && cmp_set) ? '0 : count + 1'b1;
            guard_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ctr8_flags.sv
module ctr8_flags import ctr8_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [NFLAG-1:0] set,
    input  logic [NFLAG-1:0] clr,
    input  logic [NFLAG-1:0] mask,
    output logic [NFLAG-1:0] flag_q,
    output logic [NFLAG-1:0] irq
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flag_q[i] <= 1'b0;
            else     flag_q[i] <= set[i] | (flag_q[i] & ~clr[i]);
        end
        assign irq[i] = flag_q[i] & mask[i];
    end
endmodule

// File: rtl/ctr8_timer.sv
module ctr8_timer import ctr8_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ack_ovf,
    input  logic              ack_cmp,
    input  logic              psc_clr,
    output logic              irq_ovf,
    output logic              irq_cmp
);
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [NFLAG-1:0]  mask_q;
    logic [NFLAG-1:0]  flag_q;
    logic [NFLAG-1:0]  irq_vec;
    logic [NFLAG-1:0]  flag_set;
    logic [NFLAG-1:0]  flag_clr;
    logic [CNT_W-1:0]  count;
    logic [SEL_W-1:0]  clk_sel;
    logic              ctc_mode;
    logic              tick;
    logic              cnt_ld;
    logic              ovf_set;
    logic              cmp_set;
    logic              wr_flag;

    always_comb begin
        cnt_ld   = bus_wr && (bus_addr == A_COUNT);
        wr_flag  = bus_wr && (bus_addr == A_FLAG);
        clk_sel  = ctrl_q.sel;
        ctc_mode = ctrl_q.ctc;
        flag_clr = (wr_flag ? bus_wdata[NFLAG-1:0] : '0) | {ack_cmp, ack_ovf};
        flag_set = '0;
        flag_set[FLG_OVF] = ovf_set;
        flag_set[FLG_CMP] = cmp_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            mask_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CMP:   cmp_q  <= bus_wdata;
                A_CTRL:  ctrl_q <= ctrl_t'(bus_wdata[SEL_W:0]);
                A_MASK:  mask_q <= bus_wdata[NFLAG-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_COUNT: bus_rdata = count;
            A_CMP:   bus_rdata = cmp_q;
            A_CTRL:  bus_rdata[SEL_W:0]   = ctrl_q;
            A_MASK:  bus_rdata[NFLAG-1:0] = mask_q;
            A_FLAG:  bus_rdata[NFLAG-1:0] = flag_q;
            default: bus_rdata = '0;
        endcase
    end

    ctr8_prescaler u_pre (
        .clk(clk), .rst(rst), .sel(clk_sel), .clr(psc_clr), .tick(tick)
    );

    ctr8_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .ctc(ctc_mode), .cmp_val(cmp_q),
        .ld(cnt_ld), .ld_val(bus_wdata), .count(count),
        .ovf_set(ovf_set), .cmp_set(cmp_set)
    );

    ctr8_flags u_flg (
        .clk(clk), .rst(rst), .set(flag_set), .clr(flag_clr), .mask(mask_q),
        .flag_q(flag_q), .irq(irq_vec)
    );

    assign irq_ovf = irq_vec[FLG_OVF];
    assign irq_cmp = irq_vec[FLG_CMP];
endmodule

// File: rtl/ctr8_timer_chk.sv
module ctr8_timer_chk import ctr8_pkg::*; (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [SEL_W-1:0] clk_sel,
    input logic             cnt_ld,
    input logic             ctc_mode,
    input logic [CNT_W-1:0] count,
    input logic             ovf_set,
    input logic             cmp_set,
    input logic [NFLAG-1:0] flag_q
);
    assert_stopped_R2: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == '0) |-> !tick);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_ld) |=> $stable(count));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_ld && (count == '1)) |=> ((count == '0) && flag_q[FLG_OVF]));

    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (ctc_mode && cmp_set) |=> (count == '0));

    assert_ovf_wins_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_set |=> flag_q[FLG_OVF]);

    assert_cmp_wins_R8: assert property (@(posedge clk) disable iff (rst)
        cmp_set |=> flag_q[FLG_CMP]);

    assert_load_guard_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_ld |=> !cmp_set);
endmodule

bind ctr8_timer ctr8_timer_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .clk_sel(clk_sel), .cnt_ld(cnt_ld),
    .ctc_mode(ctc_mode), .count(count), .ovf_set(ovf_set), .cmp_set(cmp_set),
    .flag_q(flag_q)
);

// File: tb/ctr8_timer_tb_top.sv
module ctr8_timer_tb_top;
    import ctr8_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ack_ovf = 1'b0;
    logic       ack_cmp = 1'b0;
    logic       psc_clr = 1'b0;
    logic       irq_ovf, irq_cmp;

    always #10 clk = ~clk;

    ctr8_timer dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_ovf(ack_ovf),
        .ack_cmp(ack_cmp), .psc_clr(psc_clr), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Independent cycle model built from the requirements.
    logic [7:0] m_cnt, m_cmp;
    logic [2:0] m_sel;
    logic       m_mode, m_blk;
    logic [1:0] m_mask, m_flg;
    int         m_pre;

    function automatic int divn(input logic [2:0] s);
        case (s)
            3'd1: return 1;    3'd2: return 8;   3'd3: return 32;
            3'd4: return 64;   3'd5: return 128; 3'd6: return 256;
            3'd7: return 1024; default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_cnt;
            3'd1: return m_cmp;
            3'd2: return {4'b0, m_mode, m_sel};
            3'd3: return {6'b0, m_mask};
            3'd4: return {6'b0, m_flg};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin : mdl
        int n;
        logic tk, hit, s_o, s_c;
        logic [1:0] clrv;
        if (rst) begin
            m_cnt = 0; m_cmp = 0; m_sel = 0; m_mode = 0; m_blk = 0;
            m_mask = 0; m_flg = 0; m_pre = 0;
        end else begin
            n  = divn(m_sel);
            tk = (n != 0) && !psc_clr && ((m_pre % n) == n - 1);
            s_o = 0; s_c = 0;
            if (bus_wr && bus_addr == 3'd0) begin
                m_cnt = bus_wdata; m_blk = 1;
            end else if (tk) begin
                hit = (m_cnt == m_cmp) && !m_blk;
                s_c = hit;
                s_o = (m_cnt == 8'hFF);
                m_cnt = (m_mode && hit) ? 8'h00 : m_cnt + 8'd1;
                m_blk = 0;
            end
            clrv = {ack_cmp, ack_ovf};
            if (bus_wr && bus_addr == 3'd4) clrv = clrv | bus_wdata[1:0];
            m_flg = (m_flg & ~clrv) | {s_c, s_o};
            if (bus_wr && bus_addr == 3'd1) m_cmp = bus_wdata;
            if (bus_wr && bus_addr == 3'd2) begin m_sel = bus_wdata[2:0]; m_mode = bus_wdata[3]; end
            if (bus_wr && bus_addr == 3'd3) m_mask = bus_wdata[1:0];
            m_pre = psc_clr ? 0 : (m_pre + 1) % 1024;
        end
    end

    // Per-cycle comparison, a quarter period after the edge.
    always @(posedge clk) begin
        #5;
        if (mon_on) begin
            case (bus_addr)
                3'd0: chk("R2", "count read", bus_rdata, m_read(bus_addr));
                3'd4: chk("R7", "flag read", bus_rdata, m_read(bus_addr));
                default: chk("R11", "reg read", bus_rdata, m_read(bus_addr));
            endcase
            chk("R6", "irq pair", {6'b0, irq_cmp, irq_ovf}, {6'b0, m_flg & m_mask});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R1: actual hung run expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] d;
        int unused_seed;
        unused_seed = $urandom(32'hC0DE5);
        idle(3);
        rst = 1'b0;
        mon_on = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v); chk("R1", "reset reg", v, 8'h00);
        end
        chk("R1", "reset irqs", {6'b0, irq_cmp, irq_ovf}, 8'h00);

        // R11: map and read-back widths
        wr(3'd2, 8'hFA); rd(3'd2, v); chk("R11", "ctrl readback", v, 8'h0A);
        wr(3'd1, 8'h37); rd(3'd1, v); chk("R11", "cmp readback", v, 8'h37);
        wr(3'd3, 8'hFF); rd(3'd3, v); chk("R11", "mask readback", v, 8'h03);
        rd(3'd7, v); chk("R11", "unmapped read", v, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h02);

        // R10 + R2: divide by 8 after a prescaler clear with a count load
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h00; psc_clr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; psc_clr = 1'b0;
        idle(7); rd(3'd0, v); chk("R10", "no tick before 8 clocks", v, 8'h00);
        idle(1); rd(3'd0, v); chk("R10", "first tick at 8 clocks", v, 8'h01);
        idle(8); rd(3'd0, v); chk("R2", "second tick div8", v, 8'h02);
        wr(3'd2, 8'h00);

        // R3: wrap and overflow flag, R6 masking
        wr(3'd3, 8'h01);
        wr(3'd0, 8'hFE);
        wr(3'd2, 8'h01);
        idle(2);
        rd(3'd0, v); chk("R3", "count after wrap", v, 8'h00);
        rd(3'd4, v); chk("R3", "overflow flag", v, 8'h01);
        chk("R6", "irq_ovf on, irq_cmp masked", {6'b0, irq_cmp, irq_ovf}, 8'h01);
        wr(3'd2, 8'h00);
        // R7: write-one clear
        wr(3'd4, 8'h01);
        rd(3'd4, v); chk("R7", "w1c overflow", v, 8'h00);
        chk("R7", "irq_ovf after clear", {7'b0, irq_ovf}, 8'h00);

        // R9: load equal to compare gives no match on next tick
        wr(3'd1, 8'h10);
        wr(3'd0, 8'h10);
        wr(3'd3, 8'h03);
        wr(3'd2, 8'h01);
        idle(1);
        rd(3'd0, v); chk("R9", "count after guarded tick", v, 8'h11);
        rd(3'd4, v); chk("R9", "no compare flag", v, 8'h00);
        wr(3'd2, 8'h00);

        // R4: match sets compare flag
        wr(3'd0, 8'h0E);
        wr(3'd2, 8'h01);
        idle(2);
        rd(3'd4, v); chk("R4", "no flag before match", v, 8'h00);
        idle(1);
        rd(3'd4, v); chk("R4", "compare flag set", v, 8'h02);
        chk("R6", "irq_cmp raised", {7'b0, irq_cmp}, 8'h01);
        wr(3'd2, 8'h00);

        // R7: acknowledge clears
        ack_cmp = 1'b1; @(negedge clk); ack_cmp = 1'b0;
        rd(3'd4, v); chk("R7", "ack clears compare flag", v, 8'h00);

        // R8: set and clear in the same cycle
        wr(3'd0, 8'h0F);
        wr(3'd2, 8'h01);
        idle(1);
        ack_cmp = 1'b1; bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h02;
        @(negedge clk);
        ack_cmp = 1'b0; bus_wr = 1'b0;
        rd(3'd4, v); chk("R8", "set beats clear", v, 8'h02);
        wr(3'd2, 8'h00);

        // R5: clear-on-match period of compare + 1
        wr(3'd1, 8'h04);
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h03);
        wr(3'd2, 8'h09);
        idle(4);
        rd(3'd0, v); chk("R5", "count at compare", v, 8'h04);
        rd(3'd4, v); chk("R5", "no flag yet", v, 8'h00);
        idle(1);
        rd(3'd0, v); chk("R5", "reload to zero", v, 8'h00);
        rd(3'd4, v); chk("R5", "flag at reload", v, 8'h02);
        wr(3'd4, 8'h02);
        idle(4);
        rd(3'd0, v); chk("R5", "second period end", v, 8'h00);
        rd(3'd4, v); chk("R5", "flag again", v, 8'h02);
        wr(3'd2, 8'h00);

        // Random mix, checked each cycle by the model
        for (int i = 0; i < 6000; i++) begin
            bus_wr   = ($urandom % 6) == 0;
            bus_addr = 3'($urandom % 6);
            d        = 8'($urandom);
            if (bus_addr == 3'd2)
                d = {4'($urandom), 1'($urandom),
                     (($urandom % 5) == 0) ? 3'($urandom) : 3'($urandom % 3)};
            if (bus_addr == 3'd1 && ($urandom % 2) == 0) d = 8'($urandom % 12);
            bus_wdata = d;
            ack_ovf = ($urandom % 12) == 0;
            ack_cmp = ($urandom % 12) == 0;
            psc_clr = ($urandom % 25) == 0;
            @(negedge clk);
        end
        bus_wr = 1'b0; ack_ovf = 1'b0; ack_cmp = 1'b0; psc_clr = 1'b0;
        idle(4);
        summary();
        $finish;
    end
endmodule